// File: doc/BRIEF.md
# Self-Triggered Hit Projection Readout

This block reads out a binary pixel matrix without any external strobe. Every pixel delivers one hit bit from its discriminator. A per-pixel disable map is applied first. The map is loaded serially and committed by a strobe, and it serves both to silence noisy pixels and to define the active area. The surviving hits are reduced to one bit per column (the X projection) and one bit per row (the Y projection).

Any enabled hit raises a trigger output. A programmable delay unit turns the trigger's rising edge into a single-cycle delayed pulse, and that pulse is normally looped back onto the trigger input. A rising edge on the trigger input latches both projections in the same cycle. The block then shifts them out on two serial lines, one for X and one for Y, under a common frame-valid signal. Pixel `p` sits at row `p / N_COLS` and column `p % N_COLS` of the flattened hit vector.

Top module: `hitproj_readout`

## Requirements
- R1: While reset is asserted, and right after it, `trig_out`, `trig_dly`, `frame_valid`, `x_sdo` and `y_sdo` are 0, and every pixel is enabled.
- R2: The captured X bit for column c is the OR of the enabled hits in that column. The captured Y bit for row r is the OR of the enabled hits in that row.
- R3: `trig_out` is the OR of all enabled hits, registered once. It follows `hit_i` with one cycle of latency.
- R4: A disabled pixel affects neither `trig_out` nor either projection.
- R5: While `mask_shift` is high, each cycle shifts `mask_sdi` into a staging register at bit 0, and the existing bits move toward the highest pixel index. After N_PIX shifts, the first bit sent lands on pixel N_PIX-1. A 1 disables the pixel. The staging content becomes the active mask only on a cycle with `mask_load` high, so shifting alone never changes which pixels are enabled.
- R6: Suppose `trig_out` first reads high in cycle t and the delay setting is D. Then `trig_dly` is high for exactly one cycle, in cycle t+1+D. Further rising edges of `trig_out` are ignored while that pulse is pending.
- R7: Suppose `trig_in` reads high in cycle c after reading low in cycle c-1, and no frame is running. Then `frame_valid` is high from cycle c+1 for exactly max(N_COLS, N_ROWS) cycles. The projections that were latched are the ones that result from the hits present in cycle c-1.
- R8: Within a frame, `x_sdo` sends column N_COLS-1 first and `y_sdo` sends row N_ROWS-1 first, one bit per cycle. Once its own vector is exhausted, the shorter line sends 0.
- R9: While `frame_valid` is low, both serial lines are 0.
- R10: A `trig_in` rising edge during a frame is ignored, and the frame data and length are unchanged. A rising edge in the first cycle after a frame starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hit_i | input | N_ROWS*N_COLS | Discriminator hit bits, index row*N_COLS+col |
| mask_sdi | input | 1 | Serial disable-map data |
| mask_shift | input | 1 | Shift enable for the staging register |
| mask_load | input | 1 | Commit staging register to the active mask |
| trig_dly_cfg | input | DLY_W | Trigger delay in cycles |
| trig_out | output | 1 | Any enabled pixel hit |
| trig_dly | output | 1 | Delayed single-cycle trigger pulse |
| trig_in | input | 1 | Capture trigger, rising-edge sensitive |
| x_sdo | output | 1 | Serial X projection |
| y_sdo | output | 1 | Serial Y projection |
| frame_valid | output | 1 | High while projection bits are on the lines |

## Verification
The bench sweeps a single hit across every pixel of a non-square 4x6 matrix and then runs many pseudo-random patterns, with and without masks. A swapped row/column index or a reversed bit order would therefore show up as misplaced bits, and the unequal sizes expose any wrong padding on the shorter Y line. It shifts a partial mask without committing it, to catch a design that lets staging bits leak into the active mask. It also hits only disabled pixels, to catch masking that is applied to the projections but not to the trigger. The delay is swept at zero, small and larger values, and `trig_out` is re-triggered while a pulse is pending, which exposes off-by-one delays and duplicate pulses. A second capture edge is sent in mid-frame and another in the first idle cycle: a design that restarts the frame or refuses the immediate follow-up fails one of the two.

// File: rtl/hpr_pkg.sv
package hpr_pkg;

  typedef enum logic {
    RD_IDLE  = 1'b0,
    RD_SHIFT = 1'b1
  } rd_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hpr_mask_reg.sv
module hpr_mask_reg #(
  parameter int N_PIX = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdi,
  input  logic             shift_en,
  input  logic             load,
  output logic [N_PIX-1:0] dis_o
);

  logic [N_PIX-1:0] stage_q, stage_d;
  logic [N_PIX-1:0] dis_q, dis_d;

  always_comb begin
    stage_d = stage_q;
    dis_d   = dis_q;
    if (shift_en) begin
      stage_d = {stage_q[N_PIX-2:0], sdi};
    end
    if (load) begin
      dis_d = stage_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      dis_q   <= '0;
    end else begin
      stage_q <= stage_d;
      dis_q   <= dis_d;
    end
  end

  assign dis_o = dis_q;

endmodule

// File: rtl/hpr_proj_reduce.sv
module hpr_proj_reduce #(
  parameter int N_COLS = 8,
  parameter int N_ROWS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_ROWS*N_COLS-1:0] hit_i,
  input  logic [N_ROWS*N_COLS-1:0] dis_i,
  output logic [N_COLS-1:0]        x_o,
  output logic [N_ROWS-1:0]        y_o,
  output logic                     any_o
);

  localparam int N_PIX = N_ROWS * N_COLS;

  logic [N_PIX-1:0]  live;
  logic [N_COLS-1:0] x_d, x_q;
  logic [N_ROWS-1:0] y_d, y_q;
  logic              any_d, any_q;

  assign live  = hit_i & ~dis_i;
  assign any_d = |live;

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    logic col_or;
    always_comb begin
      col_or = 1'b0;
      for (int r = 0; r < N_ROWS; r++) begin
        col_or = col_or | live[r*N_COLS + c];
      end
    end
    assign x_d[c] = col_or;
  end

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    assign y_d[r] = |live[r*N_COLS +: N_COLS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      any_q <= 1'b0;
    end else begin
      x_q   <= x_d;
      y_q   <= y_d;
      any_q <= any_d;
    end
  end

  assign x_o   = x_q;
  assign y_o   = y_q;
  assign any_o = any_q;

endmodule

// File: rtl/hpr_trig_delay.sv
module hpr_trig_delay #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             pulse_o
);

  logic             prev_q, prev_d;
  logic             armed_q, armed_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic             rise;

  assign rise = trig_i & ~prev_q;

  always_comb begin
    prev_d  = trig_i;
    armed_d = armed_q;
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (armed_q) begin
      if (cnt_q == '0) begin
        pulse_d = 1'b1;
        armed_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (rise) begin
      if (dly_i == '0) begin
        pulse_d = 1'b1;
      end else begin
        armed_d = 1'b1;
        cnt_d   = dly_i - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/hpr_serializer.sv
module hpr_serializer
  import hpr_pkg::*;
#(
  parameter int N_COLS = 8,
  parameter int N_ROWS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [N_COLS-1:0] x_i,
  input  logic [N_ROWS-1:0] y_i,
  output logic              x_sdo,
  output logic              y_sdo,
  output logic              fv_o
);

  localparam int FRAME_LEN = max_of(N_COLS, N_ROWS);
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  rd_state_e            st_q, st_d;
  logic [FRAME_LEN-1:0] sx_q, sx_d, sy_q, sy_d;
  logic [FRAME_LEN-1:0] x_al, y_al;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 tin_q;
  logic                 start;

  assign x_al  = FRAME_LEN'(x_i) << (FRAME_LEN - N_COLS);
  assign y_al  = FRAME_LEN'(y_i) << (FRAME_LEN - N_ROWS);
  assign start = trig_i & ~tin_q;

  always_comb begin
    st_d  = st_q;
    sx_d  = sx_q;
    sy_d  = sy_q;
    cnt_d = cnt_q;
    case (st_q)
      RD_IDLE: begin
        if (start) begin
          st_d  = RD_SHIFT;
          sx_d  = x_al;
          sy_d  = y_al;
          cnt_d = '0;
        end
      end
      RD_SHIFT: begin
        sx_d  = sx_q << 1;
        sy_d  = sy_q << 1;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(FRAME_LEN - 1)) begin
          st_d = RD_IDLE;
        end
      end
      default: st_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RD_IDLE;
      sx_q  <= '0;
      sy_q  <= '0;
      cnt_q <= '0;
      tin_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sx_q  <= sx_d;
      sy_q  <= sy_d;
      cnt_q <= cnt_d;
      tin_q <= trig_i;
    end
  end

  assign fv_o  = (st_q == RD_SHIFT);
  assign x_sdo = fv_o & sx_q[FRAME_LEN-1];
  assign y_sdo = fv_o & sy_q[FRAME_LEN-1];

endmodule

// File: rtl/hitproj_readout.sv
module hitproj_readout
  import hpr_pkg::*;
#(
  parameter int N_COLS = 8,
  parameter int N_ROWS = 8,
  parameter int DLY_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_ROWS*N_COLS-1:0] hit_i,
  input  logic                     mask_sdi,
  input  logic                     mask_shift,
  input  logic                     mask_load,
  input  logic [DLY_W-1:0]         trig_dly_cfg,
  output logic                     trig_out,
  output logic                     trig_dly,
  input  logic                     trig_in,
  output logic                     x_sdo,
  output logic                     y_sdo,
  output logic                     frame_valid
);

  localparam int N_PIX     = N_ROWS * N_COLS;
  localparam int FRAME_LEN = max_of(N_COLS, N_ROWS);

  logic [N_PIX-1:0]  mask_dis;
  logic [N_COLS-1:0] proj_x;
  logic [N_ROWS-1:0] proj_y;

  hpr_mask_reg #(.N_PIX(N_PIX)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .sdi      (mask_sdi),
    .shift_en (mask_shift),
    .load     (mask_load),
    .dis_o    (mask_dis)
  );

  hpr_proj_reduce #(.N_COLS(N_COLS), .N_ROWS(N_ROWS)) u_proj (
    .clk   (clk),
    .rst_n (rst_n),
    .hit_i (hit_i),
    .dis_i (mask_dis),
    .x_o   (proj_x),
    .y_o   (proj_y),
    .any_o (trig_out)
  );

  hpr_trig_delay #(.DLY_W(DLY_W)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_i  (trig_out),
    .dly_i   (trig_dly_cfg),
    .pulse_o (trig_dly)
  );

  hpr_serializer #(.N_COLS(N_COLS), .N_ROWS(N_ROWS)) u_ser (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_in),
    .x_i    (proj_x),
    .y_i    (proj_y),
    .x_sdo  (x_sdo),
    .y_sdo  (y_sdo),
    .fv_o   (frame_valid)
  );

endmodule

// File: rtl/hpr_readout_chk.sv
module hpr_readout_chk #(
  parameter int N_PIX     = 64,
  parameter int FRAME_LEN = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_PIX-1:0] hit_i,
  input logic             mask_load,
  input logic [N_PIX-1:0] mask_dis,
  input logic             trig_out,
  input logic             trig_dly,
  input logic             frame_valid,
  input logic             x_sdo,
  input logic             y_sdo
);

  logic [15:0] fv_cnt;
  logic        past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_cnt  <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (frame_valid) fv_cnt <= fv_cnt + 16'd1;
      else             fv_cnt <= '0;
    end
  end

  // R9
  idle_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> (!x_sdo && !y_sdo));

  // R7
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (fv_cnt < 16'(FRAME_LEN)));

  // R7
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_valid) |-> ($past(fv_cnt) == 16'(FRAME_LEN - 1)));

  // R3
  trig_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(|hit_i)) |-> !trig_out);

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(mask_load)) |-> $stable(mask_dis));

  // R6
  dly_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_dly |=> !trig_dly);

endmodule

bind hitproj_readout hpr_readout_chk #(
  .N_PIX     (N_PIX),
  .FRAME_LEN (FRAME_LEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hit_i       (hit_i),
  .mask_load   (mask_load),
  .mask_dis    (mask_dis),
  .trig_out    (trig_out),
  .trig_dly    (trig_dly),
  .frame_valid (frame_valid),
  .x_sdo       (x_sdo),
  .y_sdo       (y_sdo)
);

// File: tb/hitproj_readout_tb.sv
module hitproj_readout_tb;

  localparam int C  = 6;
  localparam int R  = 4;
  localparam int NP = C * R;
  localparam int L  = (C > R) ? C : R;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] hit = '0;
  logic          m_sdi = 1'b0, m_shift = 1'b0, m_load = 1'b0;
  logic [7:0]    dcfg = '0;
  logic          trig_out, trig_dly, trig_in, x_sdo, y_sdo, fv;
  logic          use_loop = 1'b0, trig_man = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  assign trig_in = use_loop ? trig_dly : trig_man;

  hitproj_readout #(.N_COLS(C), .N_ROWS(R), .DLY_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .mask_sdi(m_sdi),
    .mask_shift(m_shift), .mask_load(m_load), .trig_dly_cfg(dcfg),
    .trig_out(trig_out), .trig_dly(trig_dly), .trig_in(trig_in),
    .x_sdo(x_sdo), .y_sdo(y_sdo), .frame_valid(fv)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [C-1:0] ex_x(input logic [NP-1:0] p, input logic [NP-1:0] m);
    logic [C-1:0] v = '0;
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++)
        if (p[r*C+c] && !m[r*C+c]) v[c] = 1'b1;
    return v;
  endfunction

  function automatic logic [R-1:0] ex_y(input logic [NP-1:0] p, input logic [NP-1:0] m);
    logic [R-1:0] v = '0;
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++)
        if (p[r*C+c] && !m[r*C+c]) v[r] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // check frame bits sampled in successive cycles starting at the current negedge
  task automatic chk_bits(input logic [C-1:0] xe, input logic [R-1:0] ye, input string tag);
    for (int k = 0; k < L; k++) begin
      logic xb, yb;
      if (k > 0) @(negedge clk);
      xb = (k < C) ? xe[C-1-k] : 1'b0;
      yb = (k < R) ? ye[R-1-k] : 1'b0;
      chk(fv == 1'b1, {tag, " R7 frame_valid"}, int'(fv), 1);
      chk(x_sdo == xb, {tag, " R2/R8 x bit"}, int'(x_sdo), int'(xb));
      chk(y_sdo == yb, {tag, " R2/R8 y bit"}, int'(y_sdo), int'(yb));
    end
  endtask

  task automatic do_frame(input logic [NP-1:0] p, input logic [NP-1:0] m, input string tag);
    @(negedge clk); hit = p;
    @(negedge clk);
    chk(trig_out == |(p & ~m), {tag, " R3/R4 trig_out"}, int'(trig_out), int'(|(p & ~m)));
    trig_man = 1'b1;
    @(negedge clk); trig_man = 1'b0;
    chk_bits(ex_x(p, m), ex_y(p, m), tag);
    @(negedge clk);
    chk(fv == 1'b0 && x_sdo == 1'b0 && y_sdo == 1'b0, {tag, " R7/R9 frame end"}, int'(fv), 0);
    hit = '0;
  endtask

  task automatic load_mask(input logic [NP-1:0] m, input logic commit);
    for (int i = NP - 1; i >= 0; i--) begin
      @(negedge clk); m_sdi = m[i]; m_shift = 1'b1;
    end
    @(negedge clk); m_shift = 1'b0; m_load = commit;
    @(negedge clk); m_load = 1'b0;
  endtask

  task automatic dly_test(input int d, input logic [NP-1:0] p);
    @(negedge clk); hit = '0; dcfg = 8'(d); use_loop = 1'b1;
    repeat (3) @(negedge clk);
    hit = p;
    for (int k = 1; k <= d + 2; k++) begin
      @(negedge clk);
      chk(trig_dly == (k == d + 2), "R6 delay pulse position", int'(trig_dly), int'(k == d + 2));
    end
    @(negedge clk);
    chk_bits(ex_x(p, '0), ex_y(p, '0), "loopback");
    @(negedge clk);
    chk(fv == 1'b0, "R7 loopback frame end", int'(fv), 0);
    hit = '0; use_loop = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(trig_out == 0 && trig_dly == 0 && fv == 0 && x_sdo == 0 && y_sdo == 0,
        "R1 outputs in reset", int'(fv), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(trig_out == 0 && fv == 0 && x_sdo == 0 && y_sdo == 0, "R1 outputs after reset", int'(trig_out), 0);
    // R1: all pixels enabled after reset
    do_frame('1, '0, "R1 all enabled");

    // R2: exhaustive single-pixel sweep
    for (int p = 0; p < NP; p++) do_frame(NP'(1) << p, '0, "R2 single pixel");

    // R2: pseudo-random patterns
    for (int n = 0; n < 30; n++) begin
      rng = nxt(rng);
      do_frame(rng[NP-1:0] & nxt(rng)[NP-1:0], '0, "R2 random");
    end

    // R5: partial shift without commit leaves all pixels enabled
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); m_sdi = 1'b1; m_shift = 1'b1;
    end
    @(negedge clk); m_shift = 1'b0;
    do_frame('1, '0, "R5 uncommitted shift");

    // R4/R5: disable column 0 and row 3, hit only those pixels
    begin
      logic [NP-1:0] m = '0;
      for (int r = 0; r < R; r++) m[r*C] = 1'b1;
      for (int c = 0; c < C; c++) m[3*C+c] = 1'b1;
      load_mask(m, 1'b1);
      do_frame(m, m, "R4 only masked hit");
      do_frame('1, m, "R4 full hit with mask");
      for (int p = 0; p < NP; p++) do_frame(NP'(1) << p, m, "R5 masked sweep");
      // R5: staging shift without commit keeps this mask active
      load_mask('0, 1'b0);
      do_frame('1, m, "R5 mask held without load");
    end

    // random masks with random hits
    for (int n = 0; n < 12; n++) begin
      logic [NP-1:0] m, p;
      rng = nxt(rng); m = rng[NP-1:0];
      rng = nxt(rng); p = rng[NP-1:0];
      load_mask(m, 1'b1);
      do_frame(p, m, "R4 random mask");
    end
    load_mask('0, 1'b1);

    // R6: delay sweep with loopback capture
    dly_test(0, NP'(24'h000401));
    dly_test(1, NP'(24'h800020));
    dly_test(2, NP'(24'h0F0000));
    dly_test(7, NP'(24'h000C30));
    dly_test(37, NP'(24'h102040));

    // R6: re-trigger while a pulse is pending is ignored
    begin
      int seen = 0;
      int at = -1;
      @(negedge clk); dcfg = 8'd12; hit = '0;
      repeat (3) @(negedge clk);
      hit = NP'(1);
      for (int k = 1; k <= 30; k++) begin
        @(negedge clk);
        if (k == 3) hit = '0;
        if (k == 5) hit = NP'(1);
        if (trig_dly) begin seen++; at = k; end
      end
      chk(seen == 1, "R6 single pulse under retrigger", seen, 1);
      chk(at == 14, "R6 pulse position under retrigger", at, 14);
      hit = '0;
      repeat (3) @(negedge clk);
    end

    // R10: mid-frame edge ignored, immediate follow-up accepted
    begin
      logic [NP-1:0] p1 = NP'(24'hA50003);
      logic [NP-1:0] p2 = NP'(24'h00F00C);
      @(negedge clk); hit = p1;
      @(negedge clk); trig_man = 1'b1;
      @(negedge clk); trig_man = 1'b0;
      for (int k = 0; k < L; k++) begin
        logic xb, yb;
        if (k > 0) @(negedge clk);
        if (k == 1) hit = p2;
        if (k == 3) trig_man = 1'b1;
        if (k == 4) trig_man = 1'b0;
        xb = (k < C) ? ex_x(p1, '0)[C-1-k] : 1'b0;
        yb = (k < R) ? ex_y(p1, '0)[R-1-k] : 1'b0;
        chk(fv == 1'b1, "R10 frame kept", int'(fv), 1);
        chk(x_sdo == xb && y_sdo == yb, "R10 data unchanged", int'({x_sdo, y_sdo}), int'({xb, yb}));
      end
      @(negedge clk);
      chk(fv == 1'b0, "R10 frame length unchanged", int'(fv), 0);
      trig_man = 1'b1;
      @(negedge clk); trig_man = 1'b0;
      chk_bits(ex_x(p2, '0), ex_y(p2, '0), "R10 back-to-back");
      @(negedge clk);
      chk(fv == 1'b0, "R10 second frame end", int'(fv), 0);
      hit = '0;
    end

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule